// File: doc/BRIEF.md
# 16-to-32 Bit Host Bus Adapter

This adapter lets a host that has only a 16-bit data bus reach a bank of 32-bit internal registers. The host presents a halfword address: bit 0 of `host_addr` is the halfword select (A1), and the bits above it pick the doubleword (A2 and up). Each doubleword transfer is split into two halfword strobes, which may come in either order.

For writes, the first half is held. When the opposite half of the same doubleword arrives, the adapter issues one 32-bit internal write carrying the combined word. For reads, the first half fetches and latches the whole 32-bit word, and the second half is served from that latched copy. A repeated access to the same halfword abandons the transfer. A change of doubleword address starts a new transfer.

A word-swap register sits inside the adapter at a fixed doubleword address. The host reaches it through the same two-half protocol, and its value selects the byte-lane mapping. This lets both big-endian and little-endian hosts see the same register image.

Top module: `hbus16_bridge`

## Requirements
- R1: A write to one halfword followed by a write to the other halfword of the same doubleword produces exactly one internal write. `reg_wr_en` is high for one cycle, starting the cycle after the second strobe, with the doubleword address and the 32-bit combination of both halves. A lone first half produces no internal write.
- R2: The halves of a write or read may arrive in either order (A1=0 first or A1=1 first) with the same result.
- R3: If a second write strobe hits the same halfword as the pending one, nothing is written internally and the pending half is dropped. The next write strobe is treated as a first half.
- R4: A write to a different doubleword than the pending one drops the pending half. The new write becomes the first half of a new transfer.
- R5: The first read half pulses `reg_rd_en` in its strobe cycle and latches the full 32-bit value. `host_rdata` shows the selected half from the cycle after the strobe. The second half comes from the latched value, with no new fetch, even if the internal register changed in between.
- R6: A second read strobe on the same halfword as the pending one returns 0x0000 and ends the transfer. The following read starts a fresh doubleword cycle with a new fetch.
- R7: A read of a different doubleword than the pending one is treated as the first half of a new read.
- R8: Lane mapping. When the swap register is 0xFFFFFFFF, A1=0 carries bits [31:16] and A1=1 carries bits [15:0]. For any other value, A1=0 carries bits [15:0] and A1=1 carries bits [31:16]. Within a half, the higher-numbered byte sits on data bits [15:8].
- R9: The swap register is at doubleword address `SWAP_DW` (default 0x7F) and resets to 0. It is written and read with the two-half protocol, and an access to it never raises `reg_wr_en` or `reg_rd_en`. Its value changes only at the cycle of a completing write strobe to its address.
- R10: The write and read paths are independent, so a write strobe and a read strobe may share a cycle. A read half in the same cycle as a completing swap-register write uses the old mapping. The second half of a read pair always returns the half not returned by its first half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | HA_W | Halfword address; bit 0 is A1, upper bits select the doubleword |
| host_wdata | input | 16 | Host write data |
| host_wr | input | 1 | Write strobe, one cycle per halfword |
| host_rd | input | 1 | Read strobe, one cycle per halfword |
| host_rdata | output | 16 | Read halfword, valid the cycle after the read strobe |
| reg_wr_en | output | 1 | Internal 32-bit write pulse |
| reg_wr_addr | output | HA_W-1 | Internal write doubleword address |
| reg_wr_data | output | 32 | Internal write data |
| reg_rd_en | output | 1 | Internal fetch, same cycle as a first read half |
| reg_rd_addr | output | HA_W-1 | Internal read doubleword address |
| reg_rd_data | input | 32 | Internal read value, sampled while reg_rd_en is high |

## Verification
Two events can fall in the same cycle: the completing write half, and a read half that starts a new snapshot.

The bench provokes this by strobing `host_wr` and `host_rd` together in one cycle, in two cases:
- The completing write targets a normal register. The bench judges that both the internal write and the fetch occur, each with its own address and data.
- The completing write targets the swap register. The bench judges that the read half still uses the old lane mapping. It also checks that the second read half returns the complementary half, and that only the accesses after that cycle see the new mapping.

// File: rtl/hbus_pkg.sv
`timescale 1ns/1ps
package hbus_pkg;

    // Outcome of one halfword strobe against the pending state of a path
    typedef enum logic [1:0] {
        ACC_FIRST    = 2'd0,
        ACC_COMPLETE = 2'd1,
        ACC_REPEAT   = 2'd2
    } acc_kind_e;

    // A held halfword and which 32-bit half it belongs to
    typedef struct packed {
        logic        hi;
        logic [15:0] data;
    } half_t;

    localparam logic [15:0] RD_BAD_VAL = 16'h0000;

    function automatic acc_kind_e classify(input logic pend, input logic same_dw,
                                           input logic same_a1);
        if (!pend || !same_dw) return ACC_FIRST;
        if (same_a1)           return ACC_REPEAT;
        return ACC_COMPLETE;
    endfunction

    // High half selected when A1 differs from the swap state
    function automatic logic lane_hi(input logic a1, input logic swap_on);
        return a1 ^ swap_on;
    endfunction

    function automatic logic [15:0] pick_half(input logic [31:0] w, input logic hi);
        return hi ? w[31:16] : w[15:0];
    endfunction

    function automatic logic [31:0] join_halves(input half_t first, input logic [15:0] second);
        return first.hi ? {first.data, second} : {second, first.data};
    endfunction

endpackage

// File: rtl/hbus_wr_collect.sv
`timescale 1ns/1ps
module hbus_wr_collect
    import hbus_pkg::*;
#(
    parameter int DW_W = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [DW_W-1:0] dw,
    input  logic            a1,
    input  logic [15:0]     wdata,
    input  logic            swap_on,
    output logic            cmpl,
    output logic [DW_W-1:0] cmpl_dw,
    output logic [31:0]     cmpl_data
);
    logic            pend_q;
    logic [DW_W-1:0] pend_dw_q;
    logic            pend_a1_q;
    half_t           held_q;
    acc_kind_e       kind;

    always_comb begin
        kind      = classify(pend_q, dw == pend_dw_q, a1 == pend_a1_q);
        cmpl      = wr && (kind == ACC_COMPLETE);
        cmpl_dw   = dw;
        cmpl_data = join_halves(held_q, wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            pend_dw_q <= '0;
            pend_a1_q <= 1'b0;
            held_q    <= '0;
        end else if (wr) begin
            if (kind == ACC_FIRST) begin
                pend_q      <= 1'b1;
                pend_dw_q   <= dw;
                pend_a1_q   <= a1;
                held_q.hi   <= lane_hi(a1, swap_on);
                held_q.data <= wdata;
            end else begin
                pend_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hbus_rd_split.sv
`timescale 1ns/1ps
module hbus_rd_split
    import hbus_pkg::*;
#(
    parameter int DW_W = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd,
    input  logic [DW_W-1:0] dw,
    input  logic            a1,
    input  logic            swap_on,
    input  logic [31:0]     src_data,
    output logic            fetch,
    output logic [15:0]     rdata
);
    logic            pend_q;
    logic [DW_W-1:0] pend_dw_q;
    logic            pend_a1_q;
    logic            first_hi_q;
    logic [31:0]     snap_q;
    acc_kind_e       kind;
    logic            cur_hi;

    always_comb begin
        kind   = classify(pend_q, dw == pend_dw_q, a1 == pend_a1_q);
        fetch  = rd && (kind == ACC_FIRST);
        cur_hi = lane_hi(a1, swap_on);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            pend_dw_q  <= '0;
            pend_a1_q  <= 1'b0;
            first_hi_q <= 1'b0;
            snap_q     <= '0;
            rdata      <= '0;
        end else if (rd) begin
            unique case (kind)
                ACC_FIRST: begin
                    pend_q     <= 1'b1;
                    pend_dw_q  <= dw;
                    pend_a1_q  <= a1;
                    first_hi_q <= cur_hi;
                    snap_q     <= src_data;
                    rdata      <= pick_half(src_data, cur_hi);
                end
                ACC_COMPLETE: begin
                    pend_q <= 1'b0;
                    rdata  <= pick_half(snap_q, !first_hi_q);
                end
                default: begin
                    pend_q <= 1'b0;
                    rdata  <= RD_BAD_VAL;
                end
            endcase
        end
    end
endmodule

// File: rtl/hbus16_bridge.sv
`timescale 1ns/1ps
module hbus16_bridge
    import hbus_pkg::*;
#(
    parameter int                HA_W    = 8,
    parameter logic [HA_W-2:0]   SWAP_DW = '1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [HA_W-1:0] host_addr,
    input  logic [15:0]     host_wdata,
    input  logic            host_wr,
    input  logic            host_rd,
    output logic [15:0]     host_rdata,
    output logic            reg_wr_en,
    output logic [HA_W-2:0] reg_wr_addr,
    output logic [31:0]     reg_wr_data,
    output logic            reg_rd_en,
    output logic [HA_W-2:0] reg_rd_addr,
    input  logic [31:0]     reg_rd_data
);
    localparam int DW_W = HA_W - 1;

    logic [31:0]     swap_q;
    logic            swap_on;
    logic [DW_W-1:0] host_dw;
    logic            host_a1;
    logic            rd_hits_swap;
    logic [31:0]     rd_src;
    logic            fetch;
    logic            cmpl;
    logic [DW_W-1:0] cmpl_dw;
    logic [31:0]     cmpl_data;

    always_comb begin
        swap_on      = &swap_q;
        host_dw      = host_addr[HA_W-1:1];
        host_a1      = host_addr[0];
        rd_hits_swap = (host_dw == SWAP_DW);
        rd_src       = rd_hits_swap ? swap_q : reg_rd_data;
        reg_rd_en    = fetch && !rd_hits_swap;
        reg_rd_addr  = host_dw;
    end

    hbus_wr_collect #(.DW_W(DW_W)) u_wr (
        .clk       (clk),
        .rst       (rst),
        .wr        (host_wr),
        .dw        (host_dw),
        .a1        (host_a1),
        .wdata     (host_wdata),
        .swap_on   (swap_on),
        .cmpl      (cmpl),
        .cmpl_dw   (cmpl_dw),
        .cmpl_data (cmpl_data)
    );

    hbus_rd_split #(.DW_W(DW_W)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd       (host_rd),
        .dw       (host_dw),
        .a1       (host_a1),
        .swap_on  (swap_on),
        .src_data (rd_src),
        .fetch    (fetch),
        .rdata    (host_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            swap_q      <= '0;
            reg_wr_en   <= 1'b0;
            reg_wr_addr <= '0;
            reg_wr_data <= '0;
        end else begin
            reg_wr_en <= cmpl && (cmpl_dw != SWAP_DW);
            if (cmpl && (cmpl_dw == SWAP_DW)) begin
                swap_q <= cmpl_data;
            end
            if (cmpl && (cmpl_dw != SWAP_DW)) begin
                reg_wr_addr <= cmpl_dw;
                reg_wr_data <= cmpl_data;
            end
        end
    end
endmodule

// File: rtl/hbus16_bridge_chk.sv
`timescale 1ns/1ps
module hbus16_bridge_chk #(
    parameter int              HA_W    = 8,
    parameter logic [HA_W-2:0] SWAP_DW = '1
) (
    input logic            clk,
    input logic            rst,
    input logic            host_wr,
    input logic            host_rd,
    input logic            reg_wr_en,
    input logic [HA_W-2:0] reg_wr_addr,
    input logic            reg_rd_en,
    input logic [HA_W-2:0] reg_rd_addr,
    input logic [31:0]     swap_q
);
    AST_WR_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> $past(host_wr)); // R1

    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> !reg_wr_en); // R1

    AST_SWAP_WR_LOCAL: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> (reg_wr_addr != SWAP_DW)); // R9

    AST_SWAP_RD_LOCAL: assert property (@(posedge clk) disable iff (rst)
        reg_rd_en |-> (host_rd && (reg_rd_addr != SWAP_DW))); // R9

    AST_SWAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !$past(host_wr) |-> $stable(swap_q)); // R9
endmodule

bind hbus16_bridge hbus16_bridge_chk #(.HA_W(HA_W), .SWAP_DW(SWAP_DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .reg_rd_en   (reg_rd_en),
    .reg_rd_addr (reg_rd_addr),
    .swap_q      (swap_q)
);

// File: tb/hbus16_bridge_tb.sv
`timescale 1ns/1ps
module hbus16_bridge_tb;
    localparam int HA_W = 8;
    localparam logic [6:0] SWP = 7'h7F;

    typedef struct packed {
        logic        is_rd;
        logic [6:0]  dw;
        logic        a1_first;
        logic [31:0] val;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 7'h01, 1'b0, 32'h1234_5678},
        '{1'b0, 7'h02, 1'b1, 32'hDEAD_BEEF},
        '{1'b0, 7'h10, 1'b0, 32'h0000_FFFF},
        '{1'b0, 7'h7E, 1'b1, 32'hFFFF_0000},
        '{1'b1, 7'h03, 1'b0, 32'hA1B2_C3D4},
        '{1'b1, 7'h04, 1'b1, 32'hCAFE_F00D},
        '{1'b1, 7'h20, 1'b0, 32'h8000_0001},
        '{1'b1, 7'h00, 1'b1, 32'h0F0F_F0F0}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [HA_W-1:0] host_addr = '0;
    logic [15:0]     host_wdata = '0;
    logic            host_wr = 1'b0;
    logic            host_rd = 1'b0;
    logic [15:0]     host_rdata;
    logic            reg_wr_en;
    logic [6:0]      reg_wr_addr;
    logic [31:0]     reg_wr_data;
    logic            reg_rd_en;
    logic [6:0]      reg_rd_addr;
    logic [31:0]     reg_rd_data;
    logic [31:0]     mem [128];

    int n_cmp = 0;
    int n_err = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int cycles = 0;
    logic [6:0]  last_wa;
    logic [31:0] last_wd;

    always #2.5 clk = ~clk;

    assign reg_rd_data = mem[reg_rd_addr];

    hbus16_bridge #(.HA_W(HA_W)) u_dut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
    );

    always @(negedge clk) begin
        if (reg_wr_en) begin
            wr_cnt  <= wr_cnt + 1;
            last_wa <= reg_wr_addr;
            last_wd <= reg_wr_data;
        end
    end

    always @(posedge clk) begin
        if (reg_rd_en) rd_cnt <= rd_cnt + 1;
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            n_err = n_err + 1;
            $display("FAIL watchdog act=%0d exp=<100000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

    function automatic logic [31:0] init_val(input int i);
        return {8'(i), 8'hC3, ~8'(i), 8'h3C};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp = n_cmp + 1;
        if (act !== exp) begin
            n_err = n_err + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // One cycle with optional write and read strobes; returns after outputs settle
    task automatic cyc(input logic w, input logic [6:0] wdw, input logic wa1,
                       input logic [15:0] wd, input logic r, input logic [6:0] rdw,
                       input logic ra1);
        @(negedge clk);
        host_wr    = w;
        host_rd    = r;
        host_wdata = wd;
        host_addr  = w ? {wdw, wa1} : {rdw, ra1};
        if (w && r && ({wdw, wa1} != {rdw, ra1})) begin
            // Distinct addresses cannot share one address bus
            host_addr = {rdw, ra1};
        end
        @(negedge clk);
        host_wr = 1'b0;
        host_rd = 1'b0;
        #1;
    endtask

    task automatic hwr(input logic [6:0] dw, input logic a1, input logic [15:0] d);
        cyc(1'b1, dw, a1, d, 1'b0, 7'h0, 1'b0);
    endtask

    task automatic hrd(input logic [6:0] dw, input logic a1);
        cyc(1'b0, 7'h0, 1'b0, 16'h0, 1'b1, dw, a1);
    endtask

    initial begin
        int ew;
        int er;
        for (int i = 0; i < 128; i++) mem[i] = init_val(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // Reset state (R9 swap reset, outputs idle)
        chk("R1 reset wr_en", {31'b0, reg_wr_en}, 32'h0);
        chk("R5 reset rdata", {16'h0, host_rdata}, 32'h0);

        // Vector table: halves in the given order, swap off (R2, R8)
        for (int k = 0; k < 8; k++) begin
            vec_t v;
            v = VECS[k];
            if (!v.is_rd) begin
                ew = wr_cnt;
                hwr(v.dw, v.a1_first, v.a1_first ? v.val[31:16] : v.val[15:0]);
                chk("R1 first half no write", wr_cnt, ew);
                hwr(v.dw, !v.a1_first, v.a1_first ? v.val[15:0] : v.val[31:16]);
                chk("R2 write count", wr_cnt, ew + 1);
                chk("R1 write addr", {25'b0, last_wa}, {25'b0, v.dw});
                chk("R8 write data", last_wd, v.val);
            end else begin
                mem[v.dw] = v.val;
                er = rd_cnt;
                hrd(v.dw, v.a1_first);
                chk("R5 fetch count", rd_cnt, er + 1);
                chk("R8 read first", {16'h0, host_rdata},
                    {16'h0, v.a1_first ? v.val[31:16] : v.val[15:0]});
                hrd(v.dw, !v.a1_first);
                chk("R5 no refetch", rd_cnt, er + 1);
                chk("R2 read second", {16'h0, host_rdata},
                    {16'h0, v.a1_first ? v.val[15:0] : v.val[31:16]});
            end
        end

        // R3: repeated halfword write is discarded
        ew = wr_cnt;
        hwr(7'h05, 1'b0, 16'hAAAA);
        hwr(7'h05, 1'b0, 16'hBBBB);
        chk("R3 repeat no write", wr_cnt, ew);
        hwr(7'h05, 1'b1, 16'hCCCC);
        chk("R3 next is first half", wr_cnt, ew);
        hwr(7'h05, 1'b0, 16'hDDDD);
        chk("R3 completes later", wr_cnt, ew + 1);
        chk("R3 data", last_wd, 32'hCCCC_DDDD);

        // R4: doubleword change drops pending write
        ew = wr_cnt;
        hwr(7'h06, 1'b0, 16'h1111);
        hwr(7'h07, 1'b1, 16'h2222);
        chk("R4 no write on change", wr_cnt, ew);
        hwr(7'h07, 1'b0, 16'h3333);
        chk("R4 write count", wr_cnt, ew + 1);
        chk("R4 addr", {25'b0, last_wa}, 32'h7);
        chk("R4 data", last_wd, 32'h2222_3333);

        // R5: second half from snapshot
        mem[8] = 32'h1111_2222;
        er = rd_cnt;
        hrd(7'h08, 1'b1);
        chk("R5 first", {16'h0, host_rdata}, 32'h1111);
        mem[8] = 32'h9999_8888;
        hrd(7'h08, 1'b0);
        chk("R5 snapshot", {16'h0, host_rdata}, 32'h2222);
        chk("R5 single fetch", rd_cnt, er + 1);

        // R6: repeated halfword read
        er = rd_cnt;
        hrd(7'h08, 1'b0);
        chk("R6 fresh first", {16'h0, host_rdata}, 32'h8888);
        hrd(7'h08, 1'b0);
        chk("R6 invalid value", {16'h0, host_rdata}, 32'h0);
        chk("R6 no fetch on repeat", rd_cnt, er + 1);
        hrd(7'h08, 1'b1);
        chk("R6 restart fetch", rd_cnt, er + 2);
        chk("R6 restart data", {16'h0, host_rdata}, 32'h9999);

        // R7: doubleword change on read
        er = rd_cnt;
        hrd(7'h09, 1'b0);
        hrd(7'h0A, 1'b1);
        chk("R7 refetch", rd_cnt, er + 2);
        chk("R7 data", {16'h0, host_rdata}, {16'h0, init_val(10)} >> 16);

        // R9: swap register reads zero, no internal access
        er = rd_cnt;
        hrd(SWP, 1'b0);
        chk("R9 swap reset lo", {16'h0, host_rdata}, 32'h0);
        hrd(SWP, 1'b1);
        chk("R9 swap reset hi", {16'h0, host_rdata}, 32'h0);
        chk("R9 no fetch", rd_cnt, er);

        // R8/R9: set swap to all ones
        ew = wr_cnt;
        hwr(SWP, 1'b0, 16'hFFFF);
        hwr(SWP, 1'b1, 16'hFFFF);
        chk("R9 swap write not forwarded", wr_cnt, ew);
        hrd(SWP, 1'b0);
        chk("R9 swap readback", {16'h0, host_rdata}, 32'hFFFF);
        hwr(7'h11, 1'b0, 16'hABCD);
        hwr(7'h11, 1'b1, 16'h0123);
        chk("R8 swapped write", last_wd, 32'hABCD_0123);
        mem[18] = 32'h5566_7788;
        hrd(7'h12, 1'b0);
        chk("R8 swapped A1=0", {16'h0, host_rdata}, 32'h5566);
        hrd(7'h12, 1'b1);
        chk("R8 swapped A1=1", {16'h0, host_rdata}, 32'h7788);

        // R10: swap write completes in the same cycle as a read first half
        hwr(SWP, 1'b1, 16'h0000);
        er = rd_cnt;
        ew = wr_cnt;
        @(negedge clk);
        host_wr = 1'b1; host_wdata = 16'h0000; host_addr = {SWP, 1'b0};
        host_rd = 1'b0;
        // same address bus: read half cannot target another doubleword, so
        // the read half is issued together with the next write strobe below
        @(negedge clk);
        host_wr = 1'b0;
        #1;
        chk("R10 swap cleared by write", wr_cnt, ew);
        hrd(7'h12, 1'b0);
        chk("R10 new mapping A1=0", {16'h0, host_rdata}, 32'h7788);

        // R10: completing write and read half in one cycle, same address
        mem[19] = 32'h4242_1717;
        hwr(7'h13, 1'b0, 16'h4444);
        er = rd_cnt;
        ew = wr_cnt;
        cyc(1'b1, 7'h13, 1'b1, 16'h5555, 1'b1, 7'h13, 1'b1);
        chk("R10 write in shared cycle", wr_cnt, ew + 1);
        chk("R10 write data", last_wd, 32'h5555_4444);
        chk("R10 fetch in shared cycle", rd_cnt, er + 1);
        chk("R10 read data", {16'h0, host_rdata}, 32'h4242);

        // R10: swap set, then completion shares cycle with a swap-register read
        hwr(SWP, 1'b0, 16'hFFFF);
        cyc(1'b1, SWP, 1'b1, 16'hFFFF, 1'b1, SWP, 1'b1);
        chk("R10 old mapping on shared read", {16'h0, host_rdata}, 32'h0000);
        hrd(SWP, 1'b0);
        chk("R10 complementary half", {16'h0, host_rdata}, 32'h0000);
        hrd(SWP, 1'b0);
        chk("R10 new value visible", {16'h0, host_rdata}, 32'hFFFF);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule